// File: doc/BRIEF.md
# Tear-Free Wide Counter on a Narrow Register Bus

This block holds a free-running 32-bit counter that software reaches over a 16-bit synchronous register bus. The counter is wider than the bus, so it is read and written in two halves. Between two bus accesses the counter moves on. If nothing guards the halves, a carry out of the lower half can make the halves disagree. The block prevents this with two 16-bit side registers.

The first is a snapshot register. A read of the lower half returns the live low 16 bits. In that same cycle the snapshot register captures the live upper 16 bits, and a later read of the upper-half address returns the snapshot. The second is a staging register for writes, which run the other way round. Software first writes the upper half, and that value only goes into staging. A later write of the lower half then loads all 32 bits into the counter in one cycle. Software therefore reads low then high, and writes high then low.

The bus is a plain strobe interface with one address bit and separate read and write strobes. Read data comes from a register and is valid one cycle after the read strobe. It then stays unchanged until the next read.

Top module: `wide_counter_bus`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the counter, the snapshot register, the staging register and `rdata` to zero. In the first cycle after reset is released the counter value is 0.
- R2: In every cycle without a lower-half write, the counter advances by one. It wraps from 0xFFFF_FFFF to 0x0000_0000.
- R3: A read strobe with `addr` = 0 (lower half) puts the counter's bits [15:0], as they stood in the strobe cycle, on `rdata` after the next rising edge.
- R4: A read strobe with `addr` = 0 also loads the counter's bits [31:16] from that same cycle into the snapshot register. A read strobe with `addr` = 1 (upper half) returns the snapshot and not the live upper half.
- R5: If no lower-half read has happened since reset, an upper-half read returns 0, whatever the counter holds.
- R6: A write strobe with `addr` = 1 stores `wdata` in the staging register only. The counter keeps counting without change.
- R7: A write strobe with `addr` = 0 loads the counter with {staging, `wdata`}. This load takes priority over the increment, so the counter holds exactly that value in the next cycle.
- R8: `rdata` keeps its value in every cycle without a read strobe, including cycles that carry a write.
- R9: The staging register keeps its value across lower-half writes, so more than one lower-half write can reuse one staged upper half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 1 | Half select: 0 = lower 16 bits, 1 = upper 16 bits |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data, valid the cycle after a read strobe |

## Verification
The assertions assume that `rd_en`, `wr_en`, `addr` and `wdata` hold known values at every edge after reset. They also assume that one address is used per cycle, so a single strobe pair never names both halves at once. The stimulus changes inputs only on the falling edge and always drives defined values. Its random phase mixes read-only, write-only, combined and idle cycles at both addresses. Directed cases set up a carry across the half boundary between the two accesses, and the full 32-bit wrap.

// File: rtl/wcb_pkg.sv
package wcb_pkg;

  localparam int BUS_W_DEFAULT = 16;

  // Address bit selects which half of the counter is accessed.
  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_sel_e;

  // Decoded per-cycle strobes.
  typedef struct packed {
    logic rd_lo;
    logic rd_hi;
    logic wr_lo;
    logic wr_hi;
  } bus_strobe_t;

endpackage

// File: rtl/wcb_decode.sv
module wcb_decode
  import wcb_pkg::*;
(
  input  logic        addr,
  input  logic        rd_en,
  input  logic        wr_en,
  output bus_strobe_t strobe
);

  half_sel_e sel;

  always_comb begin
    sel          = half_sel_e'(addr);
    strobe.rd_lo = rd_en && (sel == HALF_LO);
    strobe.rd_hi = rd_en && (sel == HALF_HI);
    strobe.wr_lo = wr_en && (sel == HALF_LO);
    strobe.wr_hi = wr_en && (sel == HALF_HI);
  end

endmodule

// File: rtl/wcb_side_reg.sv
// Enable-loaded register used for both the read snapshot and the write staging.
module wcb_side_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end

endmodule

// File: rtl/wcb_counter.sv
module wcb_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else           cnt <= cnt + ONE;
  end

endmodule

// File: rtl/wcb_read_port.sv
module wcb_read_port #(
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_lo,
  input  logic             rd_hi,
  input  logic [BUS_W-1:0] lo_live,
  input  logic [BUS_W-1:0] hi_snap,
  output logic [BUS_W-1:0] rdata
);

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_lo) rdata <= lo_live;
    else if (rd_hi) rdata <= hi_snap;
  end

endmodule

// File: rtl/wide_counter_bus.sv
module wide_counter_bus
  import wcb_pkg::*;
#(
  parameter int BUS_W = BUS_W_DEFAULT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             addr,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] rdata
);

  localparam int CNT_W = 2 * BUS_W;

  bus_strobe_t      strobe;
  logic [CNT_W-1:0] cnt_q;
  logic [BUS_W-1:0] hold_q;
  logic [BUS_W-1:0] stage_q;

  wcb_decode u_decode (
    .addr   (addr),
    .rd_en  (rd_en),
    .wr_en  (wr_en),
    .strobe (strobe)
  );

  // Upper half captured when the lower half is read.
  wcb_side_reg #(.W(BUS_W)) u_hold (
    .clk  (clk),
    .rst  (rst),
    .load (strobe.rd_lo),
    .d    (cnt_q[CNT_W-1:BUS_W]),
    .q    (hold_q)
  );

  // Upper half waiting for the committing lower-half write.
  wcb_side_reg #(.W(BUS_W)) u_stage (
    .clk  (clk),
    .rst  (rst),
    .load (strobe.wr_hi),
    .d    (wdata),
    .q    (stage_q)
  );

  wcb_counter #(.CNT_W(CNT_W)) u_counter (
    .clk      (clk),
    .rst      (rst),
    .load     (strobe.wr_lo),
    .load_val ({stage_q, wdata}),
    .cnt      (cnt_q)
  );

  wcb_read_port #(.BUS_W(BUS_W)) u_read (
    .clk     (clk),
    .rst     (rst),
    .rd_lo   (strobe.rd_lo),
    .rd_hi   (strobe.rd_hi),
    .lo_live (cnt_q[BUS_W-1:0]),
    .hi_snap (hold_q),
    .rdata   (rdata)
  );

endmodule

// File: rtl/wcb_checker.sv
module wcb_checker #(
  parameter int BUS_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               addr,
  input logic               rd_en,
  input logic               wr_en,
  input logic [BUS_W-1:0]   wdata,
  input logic [BUS_W-1:0]   rdata,
  input logic [2*BUS_W-1:0] cnt,
  input logic [BUS_W-1:0]   hold,
  input logic [BUS_W-1:0]   stage
);

  localparam int CNT_W = 2 * BUS_W;

  logic rst_seen;
  always_ff @(posedge clk) rst_seen <= rst;

  // R1: one edge after a reset edge, all state is zero.
  always @(posedge clk) begin
    if (rst_seen === 1'b1) begin
      assert_reset_clear_R1: assert (cnt == '0 && hold == '0 && stage == '0 && rdata == '0)
        else $error("reset state not cleared");
    end
  end

  assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && !addr) |=> cnt == $past(cnt) + CNT_W'(1));

  assert_rdata_lo_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !addr) |=> rdata == $past(cnt[BUS_W-1:0]));

  assert_snap_capture_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !addr) |=> hold == $past(cnt[CNT_W-1:BUS_W]));

  assert_rdata_hi_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr) |=> rdata == $past(hold));

  assert_snap_steady_R5: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && !addr) |=> $stable(hold));

  assert_stage_load_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr) |=> stage == $past(wdata));

  assert_commit_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !addr) |=> cnt == {$past(stage), $past(wdata)});

  assert_rdata_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));

  assert_stage_keep_R9: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr) |=> $stable(stage));

endmodule

bind wide_counter_bus wcb_checker #(.BUS_W(BUS_W)) u_wcb_checker (
  .clk   (clk),
  .rst   (rst),
  .addr  (addr),
  .rd_en (rd_en),
  .wr_en (wr_en),
  .wdata (wdata),
  .rdata (rdata),
  .cnt   (cnt_q),
  .hold  (hold_q),
  .stage (stage_q)
);

// File: tb/wide_counter_bus_test.sv
module wide_counter_bus_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        addr = 1'b0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  // Bench-side expectation state.
  logic [31:0] m_cnt;
  logic [15:0] m_hold, m_stage, m_rdata;

  always #2 clk = ~clk;

  wide_counter_bus uut (
    .clk   (clk),
    .rst   (rst),
    .addr  (addr),
    .rd_en (rd_en),
    .wr_en (wr_en),
    .wdata (wdata),
    .rdata (rdata)
  );

  function automatic logic [15:0] exp_read(input logic a, input logic [31:0] c,
                                           input logic [15:0] h);
    return a ? h : c[15:0];
  endfunction

  function automatic logic [31:0] exp_next(input logic w, input logic a,
                                           input logic [31:0] c, input logic [15:0] s,
                                           input logic [15:0] d);
    return (w && !a) ? {s, d} : c + 32'd1;
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: rdata=%h expected=%h", tag, got, exp);
    end
  endtask

  // One bus cycle: drive at the falling edge, update expectations at the
  // rising edge, sample 1 ns later.
  task automatic step(input logic r, input logic w, input logic a,
                      input logic [15:0] d, input string tag, input bit chk);
    logic [31:0] pre;
    @(negedge clk);
    rd_en = r; wr_en = w; addr = a; wdata = d;
    @(posedge clk);
    #1;
    pre = m_cnt;
    if (r) m_rdata = exp_read(a, pre, m_hold);
    if (r && !a) m_hold = pre[31:16];
    m_cnt = exp_next(w, a, pre, m_stage, d);
    if (w && a) m_stage = d;
    if (chk) check(tag, rdata, m_rdata);
  endtask

  task automatic rd(input logic a, input string tag);
    step(1'b1, 1'b0, a, 16'h0, tag, 1'b1);
  endtask

  task automatic wr(input logic a, input logic [15:0] d, input string tag);
    step(1'b0, 1'b1, a, d, tag, 1'b1);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 1'b0, 1'b0, 16'h0, tag, 1'b1);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_fails++;
        n_checks++;
        $display("FAIL watchdog: cycles=%0d expected=<100000", cycles);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset rdata", rdata, 16'h0000);
    m_cnt = '0; m_hold = '0; m_stage = '0; m_rdata = '0;
    rst = 1'b0;

    // R5: load a value without any lower read, then the upper read gives zero.
    wr(1'b1, 16'hABCD, "R6 stage write");
    wr(1'b0, 16'h0000, "R7 commit");
    rd(1'b1, "R5 snapshot untouched");
    check("R5 explicit zero", rdata, 16'h0000);
    rd(1'b0, "R7 low after commit");
    rd(1'b1, "R7 high after commit");
    check("R7 explicit high", rdata, 16'hABCD);

    // R6: staging alone does not disturb the counter.
    wr(1'b1, 16'h5555, "R6 stage only");
    idle("R8 idle after write");
    rd(1'b0, "R6 low unaffected");
    rd(1'b1, "R6 high unaffected");
    check("R6 explicit high", rdata, 16'hABCD);

    // R4: carry between the two reads must not tear.
    wr(1'b1, 16'h0001, "R4 setup high");
    wr(1'b0, 16'hFFFF, "R4 setup low");
    rd(1'b0, "R4 low at carry");
    check("R4 explicit low", rdata, 16'hFFFF);
    rd(1'b1, "R4 snapshot after carry");
    check("R4 explicit snapshot", rdata, 16'h0001);

    // R2: full 32-bit wrap.
    wr(1'b1, 16'hFFFF, "R2 setup high");
    wr(1'b0, 16'hFFFE, "R2 setup low");
    idle("R2 at FFFFFFFE");
    idle("R2 at FFFFFFFF");
    rd(1'b0, "R2 low after wrap");
    check("R2 explicit low", rdata, 16'h0000);
    rd(1'b1, "R2 high after wrap");
    check("R2 explicit high", rdata, 16'h0000);

    // R8: rdata holds through idle and write cycles.
    rd(1'b0, "R3 plain low");
    idle("R8 hold 1");
    wr(1'b1, 16'h7777, "R8 hold on write");
    idle("R8 hold 2");

    // R9: one staged upper half serves two commits.
    wr(1'b1, 16'h1234, "R9 stage");
    wr(1'b0, 16'h0000, "R9 first commit");
    idle("R9 gap");
    wr(1'b0, 16'h0050, "R9 second commit");
    rd(1'b0, "R9 low");
    check("R9 explicit low", rdata, 16'h0050);
    rd(1'b1, "R9 high");
    check("R9 explicit high", rdata, 16'h1234);

    // Random mix, R3 and R4 checked each cycle against expectations.
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] rv;
      logic [15:0] dv;
      rv = $urandom();
      dv = (rv[7:6] == 2'b00) ? 16'hFFFF : 16'($urandom());
      step(rv[0], rv[1] & rv[2], rv[3], dv, "R3 R4 random", 1'b1);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule